// File: doc/BRIEF.md
# Compare Unit with Event Trigger

This block is a 16-bit compare channel with two free-running 16-bit timers of its own. A timer-select bit picks which timer the channel watches. When that timer equals the programmable compare register, a 4-bit mode field sets what happens next. One mode only raises a sticky compare interrupt flag. The event mode also clears the watched timer, so the compare register acts as its period. The same event mode sends a one-cycle start pulse to an ADC when the ADC reports that it is enabled.

The parameter `HAS_TRIG` says whether the channel has the event hardware. Without it, the event mode code acts exactly like the software-interrupt mode. Software reaches the control, compare, timer and flag registers through a simple single-address port. Writes take effect at the clock edge, and reads are combinational from the same address.

Top module: `cmp_trig_unit`

## Requirements
- R1: Register map, in words of `W` bits. Address 0 is control: bits [3:0] hold the mode and bit 4 is the timer select. Address 1 is the compare value. Addresses 2 and 3 are timer 0 and timer 1, readable and writable. Address 4 holds the flags: bit 0 is the compare flag, bit 1 is the timer 0 overflow flag and bit 2 is the timer 1 overflow flag. Other addresses read as zero, and everything resets to zero.
- R2: The timer select (0 for timer 0, 1 for timer 1) chooses the timer that is compared and cleared. A new value written to it is used from the cycle after the write.
- R3: In mode 4'b1011 with `HAS_TRIG=1`, any cycle in which the selected timer equals the compare value loads zero into that timer at the next edge instead of incrementing it. A software write to the timer takes priority.
- R4: In mode 4'b1011 with `HAS_TRIG=1`, `adc_start_o` is high for exactly one cycle. It rises the cycle after a cycle in which the values newly became equal, and only if `adc_en_i` was high in that match cycle. It does not repeat while the values stay equal.
- R5: A timer cleared by the event mode does not set its overflow flag, even when the compare value is 16'hFFFF.
- R6: A timer that steps from 16'hFFFF to 0 by incrementing sets its overflow flag on that same edge.
- R7: In mode 4'b1010, a newly established match sets the compare flag on the next edge. The timer keeps counting and `adc_start_o` stays low.
- R8: All flags are sticky. Writing a one to a flag bit at address 4 clears it, writing a zero leaves it unchanged, and a set in the same cycle wins over the clear.
- R9: With `HAS_TRIG=0`, mode 4'b1011 behaves exactly like 4'b1010: it sets the compare flag, never clears a timer and never pulses `adc_start_o`.
- R10: In mode 4'b0000, and in every mode other than 4'b1010 and 4'b1011, a match sets no flag, clears no timer and sends no pulse.
- R11: Each timer increments by one every clock unless it is being written or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data at `addr_i` |
| adc_en_i | input | 1 | ADC is enabled and may be started |
| adc_start_o | output | 1 | One-cycle ADC start pulse |
| cmp_flag_o | output | 1 | Compare interrupt flag |
| tmr_flag_o | output | 2 | Overflow flags of timer 1 and timer 0 |

## Verification
A stale previous-match register would show up as a repeated or missing `adc_start_o` pulse within one cycle of a match. A wrongly gated clear shows in the timer read-back on the next cycle: either a value above the compare value, or a timer stuck at zero. A clear that leaks into the overflow path raises `tmr_flag_o` on the edge where the event mode reloads the timer from 16'hFFFF. The bench's behavioural model predicts every output and every read-back each cycle, so any of these errors is reported in the cycle where it first appears.

// File: rtl/cmp_trig_pkg.sv
`timescale 1ns/1ps
package cmp_trig_pkg;
  localparam int MODE_W  = 4;
  localparam int ADDR_W  = 3;
  localparam int NUM_TMR = 2;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_OFF = 4'b0000;
  localparam mode_t MODE_SWI = 4'b1010;
  localparam mode_t MODE_EVT = 4'b1011;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TMR0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_TMR1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

  typedef struct packed {
    logic  tsel;
    mode_t mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // only a plain increment can wrap
  assign wrap_o = !load_i && !clr_i && (cnt_q == {W{1'b1}});
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/cmp_match.sv
`timescale 1ns/1ps
module cmp_match
  import cmp_trig_pkg::*;
#(
  parameter int W        = 16,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tmr_i,
  input  logic [W-1:0] cmp_i,
  input  mode_t        mode_i,
  input  logic         adc_en_i,
  output logic         cmp_set_o,
  output logic         tmr_clr_o,
  output logic         adc_start_o
);
  logic eq, eq_q, first, act, evt, adc_q;

  assign eq    = (tmr_i == cmp_i);
  assign first = eq && !eq_q;
  assign act   = (mode_i == MODE_SWI) || (mode_i == MODE_EVT);

  generate
    if (HAS_TRIG) begin : g_trig
      assign evt = (mode_i == MODE_EVT);
    end else begin : g_no_trig
      assign evt = 1'b0;
    end
  endgenerate

  assign cmp_set_o   = act && first;
  assign tmr_clr_o   = evt && eq;
  assign adc_start_o = adc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q  <= 1'b0;
      adc_q <= 1'b0;
    end else begin
      eq_q  <= eq;
      adc_q <= evt && first && adc_en_i;
    end
  end
endmodule

// File: rtl/cmp_regs.sv
`timescale 1ns/1ps
module cmp_regs
  import cmp_trig_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [W-1:0]                  wdata_i,
  output logic [W-1:0]                  rdata_o,
  input  logic                          cmp_set_i,
  input  logic [NUM_TMR-1:0]            tmr_wrap_i,
  input  logic [NUM_TMR-1:0][W-1:0]     tmr_cnt_i,
  output ctrl_t                         ctrl_o,
  output logic [W-1:0]                  cmp_o,
  output logic [NUM_TMR-1:0]            tmr_load_o,
  output logic                          cmp_flag_o,
  output logic [NUM_TMR-1:0]            tmr_flag_o
);
  ctrl_t              ctrl_q;
  logic [W-1:0]       cmp_q;
  logic               cmp_flag_q;
  logic [NUM_TMR-1:0] tmr_flag_q;
  logic [NUM_TMR:0]   w1c;

  assign w1c = (wr_en_i && addr_i == A_FLAG) ? wdata_i[NUM_TMR:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      cmp_q      <= '0;
      cmp_flag_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_en_i && addr_i == A_CMP)  cmp_q  <= wdata_i;
      cmp_flag_q <= (cmp_flag_q && !w1c[0]) || cmp_set_i;
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tflag
    assign tmr_load_o[i] = wr_en_i && (addr_i == A_TMR0 + ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tmr_flag_q[i] <= 1'b0;
      else         tmr_flag_q[i] <= (tmr_flag_q[i] && !w1c[i+1]) || tmr_wrap_i[i];
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = W'(ctrl_q);
      A_CMP:   rdata_o = cmp_q;
      A_TMR0:  rdata_o = tmr_cnt_i[0];
      A_TMR1:  rdata_o = tmr_cnt_i[1];
      A_FLAG:  rdata_o = W'({tmr_flag_q, cmp_flag_q});
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_o      = cmp_q;
  assign cmp_flag_o = cmp_flag_q;
  assign tmr_flag_o = tmr_flag_q;
endmodule

// File: rtl/cmp_trig_unit.sv
`timescale 1ns/1ps
module cmp_trig_unit
  import cmp_trig_pkg::*;
#(
  parameter int W        = 16,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  input  logic                adc_en_i,
  output logic                adc_start_o,
  output logic                cmp_flag_o,
  output logic [NUM_TMR-1:0]  tmr_flag_o
);
  ctrl_t                      ctrl;
  logic [W-1:0]               cmp_val;
  logic [NUM_TMR-1:0][W-1:0]  tmr_cnt;
  logic [NUM_TMR-1:0]         tmr_load, tmr_wrap, tmr_clr_vec;
  logic [W-1:0]               sel_cnt;
  logic                       cmp_set, tmr_clr;

  assign sel_cnt = tmr_cnt[ctrl.tsel];

  cmp_regs #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cmp_set_i  (cmp_set),
    .tmr_wrap_i (tmr_wrap),
    .tmr_cnt_i  (tmr_cnt),
    .ctrl_o     (ctrl),
    .cmp_o      (cmp_val),
    .tmr_load_o (tmr_load),
    .cmp_flag_o (cmp_flag_o),
    .tmr_flag_o (tmr_flag_o)
  );

  cmp_match #(.W(W), .HAS_TRIG(HAS_TRIG)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmr_i       (sel_cnt),
    .cmp_i       (cmp_val),
    .mode_i      (ctrl.mode),
    .adc_en_i    (adc_en_i),
    .cmp_set_o   (cmp_set),
    .tmr_clr_o   (tmr_clr),
    .adc_start_o (adc_start_o)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tmr_clr_vec[i] = tmr_clr && (int'(ctrl.tsel) == i);
    cmp_timer #(.W(W)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load[i]),
      .load_val_i (wdata_i),
      .clr_i      (tmr_clr_vec[i]),
      .cnt_o      (tmr_cnt[i]),
      .wrap_o     (tmr_wrap[i])
    );
  end
endmodule

// File: rtl/cmp_trig_chk.sv
`timescale 1ns/1ps
module cmp_trig_chk
  import cmp_trig_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic              adc_en_i,
  input logic              adc_start_o,
  input logic              cmp_flag_o,
  input logic [1:0]        tmr_flag_o,
  input mode_t             mode_i,
  input logic              clr0_i,
  input logic              load0_i,
  input logic [W-1:0]      cnt0_i
);
  p_cmp_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag_o && !(wr_en_i && addr_i == A_FLAG && wdata_i[0])) |=> cmp_flag_o);

  p_adc_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  p_adc_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_start_o) |-> $past(adc_en_i));

  p_evt_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr0_i && !load0_i) |=> (cnt0_i == '0));

  p_evt_noflag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr0_i && !tmr_flag_o[0]) |=> !tmr_flag_o[0]);

  p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !cmp_flag_o) |=> (!cmp_flag_o && !adc_start_o));
endmodule

bind cmp_trig_unit cmp_trig_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .adc_en_i    (adc_en_i),
  .adc_start_o (adc_start_o),
  .cmp_flag_o  (cmp_flag_o),
  .tmr_flag_o  (tmr_flag_o),
  .mode_i      (ctrl.mode),
  .clr0_i      (tmr_clr_vec[0]),
  .load0_i     (tmr_load[0]),
  .cnt0_i      (tmr_cnt[0])
);

// File: tb/cmp_trig_unit_tb.sv
`timescale 1ns/1ps
module cmp_trig_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic        adc_en = 1'b0;
  logic [15:0] rdata, rdata_nt;
  logic        adc, adc_nt, cf, cf_nt;
  logic [1:0]  tf, tf_nt;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_trig_unit #(.W(16), .HAS_TRIG(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .adc_en_i(adc_en), .adc_start_o(adc), .cmp_flag_o(cf), .tmr_flag_o(tf));

  cmp_trig_unit #(.W(16), .HAS_TRIG(1'b0)) u_nt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_nt), .adc_en_i(adc_en), .adc_start_o(adc_nt), .cmp_flag_o(cf_nt), .tmr_flag_o(tf_nt));

  // behavioural reference of the event-capable channel
  int m_t0, m_t1, m_cmp, m_mode, m_sel;
  bit m_fc, m_mq, m_adc;
  bit [1:0] m_ft;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t0 = 0; m_t1 = 0; m_cmp = 0; m_mode = 0; m_sel = 0;
      m_fc = 0; m_ft = 0; m_mq = 0; m_adc = 0;
    end else begin
      int ts;
      bit eq, first, act, evt, clr, wr0, wr1, ov0, ov1;
      bit [2:0] w1c;
      ts    = (m_sel == 1) ? m_t1 : m_t0;
      eq    = (ts == m_cmp);
      first = eq && !m_mq;
      act   = (m_mode == 10) || (m_mode == 11);
      evt   = (m_mode == 11);
      clr   = evt && eq;
      wr0   = wen && addr == 3'd2;
      wr1   = wen && addr == 3'd3;
      w1c   = (wen && addr == 3'd4) ? wdata[2:0] : 3'b000;
      ov0   = !wr0 && !(clr && m_sel == 0) && m_t0 == 65535;
      ov1   = !wr1 && !(clr && m_sel == 1) && m_t1 == 65535;
      m_fc    = (m_fc && !w1c[0]) || (act && first);
      m_ft[0] = (m_ft[0] && !w1c[1]) || ov0;
      m_ft[1] = (m_ft[1] && !w1c[2]) || ov1;
      m_adc   = evt && first && adc_en;
      m_mq    = eq;
      if (wr0) m_t0 = int'(wdata);
      else if (clr && m_sel == 0) m_t0 = 0;
      else m_t0 = (m_t0 + 1) % 65536;
      if (wr1) m_t1 = int'(wdata);
      else if (clr && m_sel == 1) m_t1 = 0;
      else m_t1 = (m_t1 + 1) % 65536;
      if (wen && addr == 3'd0) begin m_mode = int'(wdata[3:0]); m_sel = int'(wdata[4]); end
      if (wen && addr == 3'd1) m_cmp = int'(wdata);
    end
  end

  function automatic int exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_mode + 16 * m_sel;
      3'd1: return m_cmp;
      3'd2: return m_t0;
      3'd3: return m_t1;
      3'd4: return int'(m_fc) + 2 * int'(m_ft[0]) + 4 * int'(m_ft[1]);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(adc == m_adc, "R4 adc_start", int'(adc), int'(m_adc));
      chk(cf == m_fc, "R8 cmp_flag", int'(cf), int'(m_fc));
      chk(tf == m_ft, "R6 tmr_flag", int'(tf), int'(m_ft));
      chk(int'(rdata) == exp_rd(addr), "R1 rdata", int'(rdata), exp_rd(addr));
      chk(!adc_nt, "R9 no-trig adc", int'(adc_nt), 0);
      if (adc) pulses++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wen = 1'b1;
    @(posedge clk); #2;
    wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v, output int v_nt);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    v = int'(rdata); v_nt = int'(rdata_nt);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, vn, p0;
    #35 rst_n = 1'b1;
    // R1: reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v, vn);
      if (a != 2 && a != 3) chk(v == 0, "R1 reset", v, 0);
    end
    // R7: software-interrupt compare, timer keeps counting
    wr(3'd1, 16'd20);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h000A);
    adc_en = 1'b1;
    idle(30);
    rd(3'd4, v, vn);
    chk(v[0] == 1'b1, "R7 flag set", v, 1);
    rd(3'd2, v, vn);
    chk(v > 20, "R7 timer runs on", v, 21);
    chk(pulses == 0, "R7 no adc", pulses, 0);
    // R8: sticky, write-one-to-clear
    idle(5);
    rd(3'd4, v, vn);
    chk(v[0] == 1'b1, "R8 sticky", v, 1);
    wr(3'd4, 16'h0000);
    rd(3'd4, v, vn);
    chk(v[0] == 1'b1, "R8 zero write ignored", v, 1);
    wr(3'd4, 16'h0001);
    rd(3'd4, v, vn);
    chk(v[0] == 1'b0, "R8 cleared", v, 0);
    // R3/R4/R9: event mode, period 11
    wr(3'd4, 16'h0007);
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h000B);
    p0 = pulses;
    idle(60);
    chk(pulses - p0 >= 4, "R4 pulses per period", pulses - p0, 5);
    rd(3'd2, v, vn);
    chk(v <= 10, "R3 timer bounded", v, 10);
    chk(vn > 10, "R9 no-trig timer not cleared", vn, 11);
    rd(3'd4, v, vn);
    chk(vn[0] == 1'b1, "R9 no-trig flag set", vn, 1);
    // R4: enable gate
    adc_en = 1'b0;
    idle(2);
    p0 = pulses;
    idle(40);
    chk(pulses == p0, "R4 gated off", pulses - p0, 0);
    // R4: held equality gives no repeat
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd0);
    idle(3);
    adc_en = 1'b1;
    p0 = pulses;
    idle(20);
    chk(pulses == p0, "R4 no repeat while equal", pulses - p0, 0);
    rd(3'd2, v, vn);
    chk(v == 0, "R3 held at zero", v, 0);
    // R6: overflow by increment
    wr(3'd0, 16'h000A);
    wr(3'd1, 16'd100);
    wr(3'd4, 16'h0007);
    wr(3'd2, 16'hFFF8);
    idle(12);
    rd(3'd4, v, vn);
    chk(v[1] == 1'b1, "R6 overflow flag", v, 2);
    // R5: event clear at FFFF sets no overflow flag
    wr(3'd0, 16'h000B);
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'h0007);
    wr(3'd2, 16'hFFF8);
    idle(12);
    rd(3'd4, v, vn);
    chk(v[1] == 1'b0, "R5 no flag on event clear", v, 0);
    rd(3'd2, v, vn);
    chk(v < 16, "R5 timer restarted", v, 12);
    // R2: select timer 1
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd200);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h001B);
    idle(30);
    rd(3'd3, v, vn);
    chk(v <= 10, "R2 timer1 cleared", v, 10);
    rd(3'd2, v, vn);
    chk(v > 200, "R2 timer0 free", v, 201);
    // R10: off and unused modes
    for (int k = 0; k < 2; k++) begin
      wr(3'd0, (k == 0) ? 16'h0000 : 16'h0005);
      wr(3'd4, 16'h0007);
      wr(3'd1, 16'd5);
      wr(3'd2, 16'd0);
      p0 = pulses;
      idle(20);
      rd(3'd4, v, vn);
      chk(v[0] == 1'b0, "R10 no flag", v, 0);
      chk(pulses == p0, "R10 no adc", pulses - p0, 0);
      rd(3'd2, v, vn);
      chk(v > 5, "R10 no clear", v, 6);
    end
    // R11: free running count
    rd(3'd2, v, vn);
    p0 = v;
    idle(9);
    rd(3'd2, v, vn);
    chk(v == p0 + 10, "R11 increments", v, p0 + 10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule